// File: doc/BRIEF.md
# Look-Ahead Fetch Overlap Controller

This block decides when the next instruction may be fetched ahead, in a cycle that overlaps the execute or store cycle of the instruction still running, and it sequences that overlapped fetch. It holds a programmable overlap-mode trigger, an overlapped-fetch-time trigger with a four-step sequence, an overlap trigger, an instruction-buffer-loaded trigger and an overlap-conflict trigger. The conflict trigger cancels the buffer load of an overlapped fetch when a store writes one of the two words just ahead of the program counter.

The surrounding sequencer gives the block its phase flags, end-of-operation, buffer decode flags, a bank conflict flag, the program counter and the operand address. The block returns strobes for memory addressing, PC increment and buffer load, the trigger states, and the address bit that picks the memory bank. A console switch can force overlap mode; a second switch selects diagnostic mode, which moves the bank-select bit and stops an ordinary fetch from marking the buffer as loaded.

Top module: `ovl_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, every output is low when sw_ovl_i, enter_ovl_i and leave_ovl_i are low and pc_i is 0.
- R2: With sw_ovl_i low, enter_ovl_i sets the overlap-mode trigger and leave_ovl_i clears it, and xfer_o is high in that cycle. With sw_ovl_i high, both leave the trigger unchanged, xfer_o stays low and ovl_mode_o is high.
- R3: ovf_time_o rises one cycle after a cycle in which the buffer-loaded trigger is set, i_late_i is high, trap_xfer_i and end_op_i are low, and the common qualifiers hold.
- R4: ovf_time_o also rises one cycle after a cycle in which end_op_i and e_time_i are high, bank_conf_i is low and the common qualifiers hold.
- R5: Common qualifiers: overlap mode on, b_time_i low, exec_i low, ovf_time_o low, and none of buf_dp_i, buf_era_i, buf_ana_i, buf_ans_i high. If any fails, no overlapped fetch starts.
- R6: An overlapped fetch keeps ovf_time_o high for four cycles: step 0 may assert mem_req_o, step 1 asserts pc_inc_o, step 2 sets the overlap trigger (ovl_o high from step 3), step 3 may assert buf_load_o.
- R7: If the buffer-loaded trigger is set when the fetch starts, mem_req_o and buf_load_o stay low for that fetch; the start clears the trigger.
- R8: ovl_o and conf_o clear on a clock where phase_start_i and end_op_i are both high, unless step 2 sets them on that clock.
- R9: At step 2, if store_i is high and (opnd_i - pc_i) mod 2^15 is 32766 or 32767 (operand at PC-2 or PC-1), conf_o rises, and buf_load_o stays low at step 3.
- R10: bank_sel_o equals pc_i[0] when sw_diag_i is low and pc_i[14] when it is high.
- R11: i_done_i sets the buffer-loaded trigger only while sw_diag_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_ovl_i | input | 1 | Overlap console switch, high forces overlap mode |
| sw_diag_i | input | 1 | Diagnostic mode switch |
| enter_ovl_i | input | 1 | Enter-overlap instruction decoded |
| leave_ovl_i | input | 1 | Leave-overlap instruction decoded |
| i_done_i | input | 1 | Ordinary fetch cycle fetched an instruction pair |
| i_late_i | input | 1 | Late part of a fetch or indirect-address cycle |
| e_time_i | input | 1 | Execute cycle active |
| phase_start_i | input | 1 | Start step of an I, E or L cycle |
| b_time_i | input | 1 | B time active |
| end_op_i | input | 1 | End of operation of the running instruction |
| exec_i | input | 1 | Execute-remote instruction in progress |
| trap_xfer_i | input | 1 | Transfer taken in trap mode |
| buf_dp_i | input | 1 | Buffer holds a double-precision instruction |
| buf_era_i | input | 1 | Buffer holds an exclusive-or-to-accumulator instruction |
| buf_ana_i | input | 1 | Buffer holds an and-to-accumulator instruction |
| buf_ans_i | input | 1 | Buffer holds an and-to-storage instruction |
| bank_conf_i | input | 1 | Fetch and execute addresses hit the same bank |
| store_i | input | 1 | Running instruction stores to memory |
| pc_i | input | 15 | Program counter |
| opnd_i | input | 15 | Operand address |
| ovl_mode_o | output | 1 | Overlap mode in effect |
| xfer_o | output | 1 | Enter/leave instruction takes its transfer |
| ovf_time_o | output | 1 | Overlapped-fetch-time trigger |
| mem_req_o | output | 1 | Address memory from the PC |
| pc_inc_o | output | 1 | Increment the PC |
| buf_load_o | output | 1 | Load instruction buffer from memory output |
| ovl_o | output | 1 | Overlap trigger |
| conf_o | output | 1 | Overlap-conflict trigger |
| bank_sel_o | output | 1 | Memory bank select bit |

## Verification
The hardest case to reach is a store conflict that lands exactly in step 2 of an overlapped fetch. The buffer-loaded trigger must be clear, so the fetch actually reads memory, and the operand address must sit one or two words below the PC, including the wrap from PC 0 to the top of the address space. The stimulus starts each such fetch through the execute-cycle path, with store_i and the address pair held across the fetch. It then checks hits at PC-1 and PC-2 and misses at PC and PC-3, while a behavioural model compares every output on every clock.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [1:0] {
    ST_ADDR  = 2'd0,
    ST_INC   = 2'd1,
    ST_SETOV = 2'd2,
    ST_LOAD  = 2'd3
  } ovf_step_e;
endpackage

// File: rtl/ovl_permit.sv
module ovl_permit (
  input  logic mode_i,
  input  logic busy_i,
  input  logic buf_ld_i,
  input  logic i_late_i,
  input  logic e_time_i,
  input  logic b_time_i,
  input  logic end_op_i,
  input  logic exec_i,
  input  logic trap_xfer_i,
  input  logic bank_conf_i,
  input  logic [3:0] blk_i,
  output logic permit_o
);
  logic common, grp_fetch, grp_exec;

  always_comb begin
    common    = mode_i && !busy_i && !b_time_i && !exec_i && (blk_i == 4'b0);
    grp_fetch = buf_ld_i && i_late_i && !trap_xfer_i && !end_op_i;
    grp_exec  = end_op_i && e_time_i && !bank_conf_i;
    permit_o  = common && (grp_fetch || grp_exec);
  end
endmodule

// File: rtl/ovl_store_chk.sv
module ovl_store_chk #(
  parameter int AW = 15
) (
  input  logic [AW-1:0] opnd_i,
  input  logic [AW-1:0] pc_i,
  output logic          hit_o
);
  logic [AW-1:0] diff;

  // operand + ~pc + 1; top AW-1 bits all ones => operand is pc-1 or pc-2
  always_comb begin
    diff  = opnd_i + ~pc_i + {{(AW-1){1'b0}}, 1'b1};
    hit_o = &diff[AW-1:1];
  end
endmodule

// File: rtl/ovl_bank_sel.sv
module ovl_bank_sel #(
  parameter int AW       = 15,
  parameter int NORM_BIT = 0,
  parameter int DIAG_BIT = AW - 1
) (
  input  logic [AW-1:0] addr_i,
  input  logic          diag_i,
  output logic          bank_o
);
  assign bank_o = diag_i ? addr_i[DIAG_BIT] : addr_i[NORM_BIT];
endmodule

// File: rtl/ovl_ctrl.sv
module ovl_ctrl #(
  parameter int AW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sw_ovl_i,
  input  logic          sw_diag_i,
  input  logic          enter_ovl_i,
  input  logic          leave_ovl_i,
  input  logic          i_done_i,
  input  logic          i_late_i,
  input  logic          e_time_i,
  input  logic          phase_start_i,
  input  logic          b_time_i,
  input  logic          end_op_i,
  input  logic          exec_i,
  input  logic          trap_xfer_i,
  input  logic          buf_dp_i,
  input  logic          buf_era_i,
  input  logic          buf_ana_i,
  input  logic          buf_ans_i,
  input  logic          bank_conf_i,
  input  logic          store_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] opnd_i,
  output logic          ovl_mode_o,
  output logic          xfer_o,
  output logic          ovf_time_o,
  output logic          mem_req_o,
  output logic          pc_inc_o,
  output logic          buf_load_o,
  output logic          ovl_o,
  output logic          conf_o,
  output logic          bank_sel_o
);
  import ovl_pkg::*;

  logic      mode_q, busy_q, fmem_q, buf_ld_q, ovl_q, conf_q;
  ovf_step_e step_q;
  logic      permit, st_hit, clr_ov, set_ov, set_conf;

  assign ovl_mode_o = mode_q | sw_ovl_i;
  assign xfer_o     = (enter_ovl_i | leave_ovl_i) & ~sw_ovl_i;

  ovl_permit u_permit (
    .mode_i      (ovl_mode_o),
    .busy_i      (busy_q),
    .buf_ld_i    (buf_ld_q),
    .i_late_i    (i_late_i),
    .e_time_i    (e_time_i),
    .b_time_i    (b_time_i),
    .end_op_i    (end_op_i),
    .exec_i      (exec_i),
    .trap_xfer_i (trap_xfer_i),
    .bank_conf_i (bank_conf_i),
    .blk_i       ({buf_dp_i, buf_era_i, buf_ana_i, buf_ans_i}),
    .permit_o    (permit)
  );

  ovl_store_chk #(.AW(AW)) u_store (
    .opnd_i (opnd_i),
    .pc_i   (pc_i),
    .hit_o  (st_hit)
  );

  ovl_bank_sel #(.AW(AW)) u_bank (
    .addr_i (pc_i),
    .diag_i (sw_diag_i),
    .bank_o (bank_sel_o)
  );

  assign clr_ov   = phase_start_i & end_op_i;
  assign set_ov   = busy_q && (step_q == ST_SETOV);
  assign set_conf = set_ov && store_i && st_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= 1'b0;
      busy_q   <= 1'b0;
      step_q   <= ST_ADDR;
      fmem_q   <= 1'b0;
      buf_ld_q <= 1'b0;
      ovl_q    <= 1'b0;
      conf_q   <= 1'b0;
    end else begin
      if (!sw_ovl_i && enter_ovl_i)      mode_q <= 1'b1;
      else if (!sw_ovl_i && leave_ovl_i) mode_q <= 1'b0;

      if (busy_q) begin
        step_q <= ovf_step_e'(step_q + 2'd1);
        if (step_q == ST_LOAD) busy_q <= 1'b0;
      end else if (permit) begin
        busy_q   <= 1'b1;
        step_q   <= ST_ADDR;
        fmem_q   <= ~buf_ld_q;
        buf_ld_q <= 1'b0;
      end
      if (i_done_i && !sw_diag_i) buf_ld_q <= 1'b1;

      if (set_ov)      ovl_q <= 1'b1;
      else if (clr_ov) ovl_q <= 1'b0;

      if (set_conf)    conf_q <= 1'b1;
      else if (clr_ov) conf_q <= 1'b0;
    end
  end

  assign ovf_time_o = busy_q;
  assign mem_req_o  = busy_q && (step_q == ST_ADDR) && fmem_q;
  assign pc_inc_o   = busy_q && (step_q == ST_INC);
  assign buf_load_o = busy_q && (step_q == ST_LOAD) && fmem_q && !conf_q;
  assign ovl_o      = ovl_q;
  assign conf_o     = conf_q;

  a_r6_inc_after_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> pc_inc_o);
  a_r6_ovl_after_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_inc_o |=> ##1 ovl_o);
  a_r9_no_load_in_conf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_load_o |-> !conf_o);
  a_r2_switch_holds_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_ovl_i |=> (mode_q == $past(mode_q)));
  a_r5_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_time_o && (buf_dp_i || buf_era_i || buf_ana_i || buf_ans_i)) |=> !ovf_time_o);
  a_r7_loaded_no_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_time_o && buf_ld_q) |=> !mem_req_o);
endmodule

// File: tb/test_ovl_ctrl.sv
module test_ovl_ctrl;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sw_ovl_i = 0, sw_diag_i = 0, enter_ovl_i = 0, leave_ovl_i = 0;
  logic i_done_i = 0, i_late_i = 0, e_time_i = 0, phase_start_i = 0;
  logic b_time_i = 0, end_op_i = 0, exec_i = 0, trap_xfer_i = 0;
  logic buf_dp_i = 0, buf_era_i = 0, buf_ana_i = 0, buf_ans_i = 0;
  logic bank_conf_i = 0, store_i = 0;
  logic [14:0] pc_i = '0, opnd_i = '0;
  logic ovl_mode_o, xfer_o, ovf_time_o, mem_req_o, pc_inc_o, buf_load_o;
  logic ovl_o, conf_o, bank_sel_o;

  int checks = 0, failures = 0;
  int n_ovf = 0, n_mem = 0, n_load = 0, n_conf = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  ovl_ctrl i_ovl_ctrl (.*);

  // behavioural reference state
  bit m_mode, m_busy, m_fmem, m_bufld, m_ovl, m_conf;
  int m_step;

  function automatic bit m_hit();
    int d;
    d = (int'(opnd_i) - int'(pc_i) + 32768) % 32768;
    return d >= 32766;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = 0; m_busy = 0; m_fmem = 0; m_bufld = 0; m_ovl = 0; m_conf = 0; m_step = 0;
    end else begin
      bit eff, ok, g1, g5, s2, clr;
      eff = m_mode | sw_ovl_i;
      ok  = eff && !m_busy && !b_time_i && !exec_i &&
            !(buf_dp_i || buf_era_i || buf_ana_i || buf_ans_i);
      g1  = m_bufld && i_late_i && !trap_xfer_i && !end_op_i;
      g5  = end_op_i && e_time_i && !bank_conf_i;
      s2  = m_busy && m_step == 2;
      clr = phase_start_i && end_op_i;
      if (!sw_ovl_i && enter_ovl_i) m_mode = 1;
      else if (!sw_ovl_i && leave_ovl_i) m_mode = 0;
      if (s2) m_ovl = 1; else if (clr) m_ovl = 0;
      if (s2 && store_i && m_hit()) m_conf = 1; else if (clr) m_conf = 0;
      if (m_busy) begin
        if (m_step == 3) m_busy = 0;
        m_step = (m_step + 1) % 4;
      end else if (ok && (g1 || g5)) begin
        m_busy = 1; m_step = 0; m_fmem = !m_bufld; m_bufld = 0;
      end
      if (i_done_i && !sw_diag_i) m_bufld = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp(input logic a, input bit e, input string req);
    chk(a === e, req, int'(a), int'(e));
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      cmp(ovf_time_o, m_busy, "R3 ovf_time");
      cmp(mem_req_o, m_busy && m_step == 0 && m_fmem, "R7 mem_req");
      cmp(pc_inc_o, m_busy && m_step == 1, "R6 pc_inc");
      cmp(buf_load_o, m_busy && m_step == 3 && m_fmem && !m_conf, "R6 buf_load");
      cmp(ovl_o, m_ovl, "R8 ovl");
      cmp(conf_o, m_conf, "R9 conf");
      cmp(bank_sel_o, sw_diag_i ? pc_i[14] : pc_i[0], "R10 bank_sel");
      cmp(ovl_mode_o, m_mode | sw_ovl_i, "R2 ovl_mode");
      cmp(xfer_o, (enter_ovl_i | leave_ovl_i) & !sw_ovl_i, "R2 xfer");
      n_ovf  += int'(ovf_time_o);
      n_mem  += int'(mem_req_o);
      n_load += int'(buf_load_o);
      n_conf += int'(conf_o);
    end
  end

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk_i);
    #1;
  endtask

  task automatic zero_cnt();
    n_ovf = 0; n_mem = 0; n_load = 0; n_conf = 0;
  endtask

  // one-cycle execute-path trigger, then let the fetch and clear run
  task automatic exec_fetch();
    end_op_i = 1; e_time_i = 1; cyc(1);
    end_op_i = 0; e_time_i = 0; cyc(5);
    phase_start_i = 1; end_op_i = 1; cyc(1);
    phase_start_i = 0; end_op_i = 0; cyc(1);
  endtask

  task automatic store_case(input int pc, input int op, input int exp_conf, input string req);
    pc_i = 15'(pc); opnd_i = 15'(op); store_i = 1; zero_cnt();
    end_op_i = 1; e_time_i = 1; cyc(1);
    end_op_i = 0; e_time_i = 0; cyc(5);
    chk((n_conf > 0) == (exp_conf != 0), req, n_conf, exp_conf);
    chk(n_load == (exp_conf != 0 ? 0 : 1), req, n_load, exp_conf != 0 ? 0 : 1);
    store_i = 0;
    phase_start_i = 1; end_op_i = 1; cyc(1);
    phase_start_i = 0; end_op_i = 0; cyc(1);
    chk(conf_o == 0, "R8 conf cleared", int'(conf_o), 0);
  endtask

  initial begin
    cyc(2);
    chk({ovl_mode_o, xfer_o, ovf_time_o, mem_req_o, pc_inc_o, buf_load_o,
         ovl_o, conf_o, bank_sel_o} == 9'b0, "R1 in reset", 1, 0);
    rst_ni = 1; cyc(1);
    chk({ovf_time_o, ovl_o, conf_o, ovl_mode_o} == 4'b0, "R1 after reset", 1, 0);

    // R5: mode off blocks the execute path
    zero_cnt(); end_op_i = 1; e_time_i = 1; cyc(1); end_op_i = 0; e_time_i = 0; cyc(3);
    chk(n_ovf == 0, "R5 mode off", n_ovf, 0);

    // R2 with switch on: no transfer, mode forced only while on
    sw_ovl_i = 1; enter_ovl_i = 1; cyc(1);
    chk(xfer_o == 0 && ovl_mode_o == 1, "R2 switch on enter", int'(xfer_o), 0);
    enter_ovl_i = 0; sw_ovl_i = 0; cyc(1);
    chk(ovl_mode_o == 0, "R2 switch on leaves trigger", int'(ovl_mode_o), 0);
    enter_ovl_i = 1; cyc(1);
    chk(xfer_o == 1, "R2 enter transfers", int'(xfer_o), 1);
    enter_ovl_i = 0; cyc(1);
    chk(ovl_mode_o == 1, "R2 mode set", int'(ovl_mode_o), 1);

    // R4 + R6: execute path, buffer empty, full memory fetch
    zero_cnt(); exec_fetch();
    chk(n_ovf == 4, "R6 four steps", n_ovf, 4);
    chk(n_mem == 1 && n_load == 1, "R4 fetch reads memory", n_mem + n_load, 2);
    chk(ovl_o == 0, "R8 overlap trigger cleared", int'(ovl_o), 0);

    // R4: bank conflict blocks
    zero_cnt(); bank_conf_i = 1; end_op_i = 1; e_time_i = 1; cyc(1);
    bank_conf_i = 0; end_op_i = 0; e_time_i = 0; cyc(3);
    chk(n_ovf == 0, "R4 bank conflict blocks", n_ovf, 0);

    // R5: each blocker
    for (int b = 0; b < 6; b++) begin
      zero_cnt();
      {buf_dp_i, buf_era_i, buf_ana_i, buf_ans_i, exec_i, b_time_i} = 6'b100000 >> b;
      end_op_i = 1; e_time_i = 1; cyc(1);
      end_op_i = 0; e_time_i = 0;
      {buf_dp_i, buf_era_i, buf_ana_i, buf_ans_i, exec_i, b_time_i} = '0; cyc(3);
      chk(n_ovf == 0, "R5 blocker", n_ovf, 0);
    end

    // R3 + R7: fetch path with buffer loaded, no memory access
    zero_cnt(); i_done_i = 1; cyc(1); i_done_i = 0;
    i_late_i = 1; cyc(1); i_late_i = 0; cyc(5);
    chk(n_ovf == 4, "R3 fetch path starts", n_ovf, 4);
    chk(n_mem == 0 && n_load == 0, "R7 loaded buffer no memory", n_mem + n_load, 0);
    zero_cnt(); i_late_i = 1; cyc(1); i_late_i = 0; cyc(2);
    chk(n_ovf == 0, "R7 buffer-loaded consumed", n_ovf, 0);
    phase_start_i = 1; end_op_i = 1; cyc(1); phase_start_i = 0; end_op_i = 0; cyc(1);

    // R3: trap transfer blocks the fetch path
    zero_cnt(); i_done_i = 1; cyc(1); i_done_i = 0;
    trap_xfer_i = 1; i_late_i = 1; cyc(1); trap_xfer_i = 0; i_late_i = 0; cyc(2);
    chk(n_ovf == 0, "R3 trap transfer blocks", n_ovf, 0);
    i_late_i = 1; cyc(1); i_late_i = 0; cyc(6);
    phase_start_i = 1; end_op_i = 1; cyc(1); phase_start_i = 0; end_op_i = 0; cyc(1);

    // R11: diagnostic mode does not mark buffer loaded
    sw_diag_i = 1; zero_cnt(); i_done_i = 1; cyc(1); i_done_i = 0;
    i_late_i = 1; cyc(1); i_late_i = 0; cyc(2);
    chk(n_ovf == 0, "R11 diag leaves buffer empty", n_ovf, 0);

    // R10: bank select in both modes
    pc_i = 15'h4001; cyc(1);
    chk(bank_sel_o == 1'b1, "R10 diag bit", int'(bank_sel_o), 1);
    pc_i = 15'h4000; cyc(1);
    chk(bank_sel_o == 1'b1, "R10 diag bit high", int'(bank_sel_o), 1);
    sw_diag_i = 0; cyc(1);
    chk(bank_sel_o == 1'b0, "R10 normal bit", int'(bank_sel_o), 0);

    // R9: store conflict window
    store_case(100, 99, 1, "R9 pc-1");
    store_case(100, 98, 1, "R9 pc-2");
    store_case(100, 100, 0, "R9 pc miss");
    store_case(100, 97, 0, "R9 pc-3 miss");
    store_case(0, 32767, 1, "R9 wrap");
    store_case(1, 32767, 1, "R9 wrap pc-2");

    // R2: leave clears mode
    leave_ovl_i = 1; cyc(1); leave_ovl_i = 0; cyc(1);
    chk(ovl_mode_o == 0, "R2 leave clears", int'(ovl_mode_o), 0);

    cyc(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule